// File: doc/BRIEF.md
# Power-On Register Self-Test Sequencer

This block runs a fixed startup self-test on a 16-bit register file and the datapath around it. It shows progress and faults on an external maintenance-panel counter, which it drives only with one-cycle clear and increment pulses. Out of reset it clears the panel and checks the datapath zero flag twice: once with an all-zero operand, once with a non-zero operand. It then marks the panel with 1 and tries six data patterns. Each pattern is written to a scratch register and to a holding (bypass) register. The register copy is checked first, then the holding copy. After that the block makes two passes over the upper part of the register file. The first pass writes each address with its own value and reads it back. The second pass checks each value again and then clears the location. When every step passes, the panel is marked with 2 and the done flag stays high.

Every numbered step has its own fault code. On a mismatch the block shows the code on the panel by issuing one clear pulse and then one increment per unit of the code, with a short idle delay before each increment. It then waits in a long nested delay, raises a single reboot pulse and halts. A fault in either flag check skips the panel display, so the panel stays at 0, and goes straight to the delay and reboot. The register file has one cycle of read latency. The holding register returns its loaded value on the cycle after it is loaded. All delay counts are parameters.

FSM states and transitions:
- ST_START → ST_FLAG_ZERO.
- ST_FLAG_ZERO: goes to ST_FLAG_NZ if the flag is set, otherwise to ST_HOLD_GO.
- ST_FLAG_NZ: goes to ST_MARK_BEGIN if the flag is clear, otherwise to ST_HOLD_GO.
- ST_MARK_BEGIN → ST_PAT_WR → ST_PAT_RD → ST_PAT_CHK_REG.
- ST_PAT_CHK_REG: goes to ST_PAT_CHK_HOLD on a match, otherwise to ST_SHOW_GO.
- ST_PAT_CHK_HOLD: on a mismatch goes to ST_SHOW_GO. On a match goes to ST_PAT_WR for the next pattern, or to ST_WALK_WR after the last pattern.
- ST_WALK_WR → ST_WALK_RD → ST_WALK_CHK.
- ST_WALK_CHK: on a mismatch goes to ST_SHOW_GO. On a match goes to ST_WALK_WR, or to ST_CLR_RD after the top address.
- ST_CLR_RD → ST_CLR_CHK.
- ST_CLR_CHK: goes to ST_CLR_WR on a match, otherwise to ST_SHOW_GO.
- ST_CLR_WR: goes to ST_CLR_RD, or to ST_PASS after the top address.
- ST_PASS → ST_DONE. ST_DONE holds.
- ST_SHOW_GO → ST_SHOW_WAIT → ST_HOLD_GO, once the panel writer finishes.
- ST_HOLD_GO → ST_HOLD_WAIT → ST_REBOOT, once the timer expires.
- ST_REBOOT → ST_HALT. ST_HALT holds.

Top module: `post_selftest_seq`

## Requirements
- R1: While reset is asserted, done, reboot, rf_we and rf_re are all low.
- R2: The zero flag must read 1 when alu_operand is 0x0000, then 0 when alu_operand is 0x00FF. A wrong flag goes to the hold delay and reboot with no code loaded, so the panel reads 0.
- R3: The panel is cleared first. It is incremented to 1 after the flag checks pass, and to 2 after the last sweep location is cleared. Done then rises on the cycle after that increment.
- R4: The patterns 0x0000, 0x0055, 0x00AA, 0xAA00, 0x5500 and 0xFF00 are applied in that order to scratch address SWEEP_LO. If the register read-back of pattern i (i from 0 to 5) mismatches, the panel shows code 4+2i.
- R5: For each pattern, the holding register is loaded with the same value and checked after the register check. A mismatch shows code 5+2i.
- R6: The first sweep writes every address from SWEEP_LO (16) to 255 with its own address value and reads it back before moving on. A mismatch shows code 16.
- R7: The second sweep reads each address from 16 to 255, checks it against its address value, then writes 0 to it. A mismatch shows code 17. After a passing run, every one of these addresses holds 0.
- R8: Addresses below SWEEP_LO are never read or written, so their contents are unchanged.
- R9: A fault code N is shown as one clear pulse followed by N increment pulses. Each increment is preceded by at least PANEL_DLY cycles with no panel pulse.
- R10: Reboot rises at least HOLD_INNER×HOLD_OUTER cycles after the last panel pulse. It is a single one-cycle pulse. After it there is no register access and no panel pulse.
- R11: panel_clr and panel_inc never assert in the same cycle. rf_we and rf_re never assert in the same cycle.
- R12: Once done is high it stays high, and it is never high together with reboot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rf_we | output | 1 | Register-file write strobe |
| rf_re | output | 1 | Register-file read strobe, data returned next cycle |
| rf_addr | output | ADDR_W | Register-file address |
| rf_wdata | output | 16 | Data for register file and holding register |
| rf_rdata | input | 16 | Register-file read data, one cycle after rf_re |
| hold_ld | output | 1 | Load the holding register from rf_wdata |
| hold_q | input | 16 | Holding-register output |
| alu_operand | output | 16 | Operand driven to the datapath for the flag check |
| alu_zero | input | 1 | Datapath zero flag for alu_operand |
| panel_clr | output | 1 | Panel clear pulse |
| panel_inc | output | 1 | Panel increment pulse |
| done | output | 1 | All tests passed |
| reboot | output | 1 | One-cycle reboot request after a fault |

## Verification
The bench injects one fault at each step in turn: each pattern's register copy, each pattern's holding copy, the two flag checks, and the walk and clear passes at the bottom address, the top address and one address in the middle. A design that ran the two checks of a pattern in the wrong order, or that numbered its steps off by one, would show a neighbouring code. A design that merged the two sweeps would report 16 where 17 is expected. Counting reads per address tells the walk pass apart from the clear pass at the same address. A design that loaded the panel without the leading clear, or that released reboot before the hold had run out, fails the panel and timing checks. A clean run is checked for a panel of exactly 2, a cleared sweep range, and untouched registers below address 16.

// File: rtl/post_selftest_pkg.sv
package post_selftest_pkg;

    localparam int DATA_W   = 16;
    localparam int NUM_PAT  = 6;
    localparam int IDX_W    = $clog2(NUM_PAT);
    localparam int CODE_W   = 5;
    localparam int CODE_WALK  = 16;
    localparam int CODE_CLEAR = 17;

    typedef enum logic [4:0] {
        ST_START,
        ST_FLAG_ZERO,
        ST_FLAG_NZ,
        ST_MARK_BEGIN,
        ST_PAT_WR,
        ST_PAT_RD,
        ST_PAT_CHK_REG,
        ST_PAT_CHK_HOLD,
        ST_WALK_WR,
        ST_WALK_RD,
        ST_WALK_CHK,
        ST_CLR_RD,
        ST_CLR_CHK,
        ST_CLR_WR,
        ST_PASS,
        ST_DONE,
        ST_SHOW_GO,
        ST_SHOW_WAIT,
        ST_HOLD_GO,
        ST_HOLD_WAIT,
        ST_REBOOT,
        ST_HALT
    } seq_state_t;

    typedef enum logic [2:0] {
        PW_IDLE,
        PW_CLR,
        PW_WAIT,
        PW_INC,
        PW_FIN
    } pw_state_t;

    function automatic logic [DATA_W-1:0] test_pattern(input logic [IDX_W-1:0] idx);
        logic [DATA_W-1:0] v;
        unique case (idx)
            3'd0:    v = 16'h0000;
            3'd1:    v = 16'h0055;
            3'd2:    v = 16'h00AA;
            3'd3:    v = 16'hAA00;
            3'd4:    v = 16'h5500;
            default: v = 16'hFF00;
        endcase
        return v;
    endfunction

    function automatic logic [CODE_W-1:0] reg_fault_code(input logic [IDX_W-1:0] idx);
        return CODE_W'(4) + CODE_W'({idx, 1'b0});
    endfunction

    function automatic logic [CODE_W-1:0] hold_fault_code(input logic [IDX_W-1:0] idx);
        return CODE_W'(5) + CODE_W'({idx, 1'b0});
    endfunction

endpackage

// File: rtl/sweep_addr_ctr.sv
module sweep_addr_ctr #(
    parameter int ADDR_W   = 8,
    parameter int SWEEP_LO = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    localparam logic [ADDR_W-1:0] LO_VAL  = ADDR_W'(SWEEP_LO);
    localparam logic [ADDR_W-1:0] TOP_VAL = {ADDR_W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= LO_VAL;
        end else if (load) begin
            addr <= LO_VAL;
        end else if (step) begin
            addr <= addr + 1'b1;
        end
    end

    assign last = (addr == TOP_VAL);
endmodule

// File: rtl/panel_pulse_writer.sv
module panel_pulse_writer
    import post_selftest_pkg::*;
#(
    parameter int PANEL_DLY = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CODE_W-1:0] code,
    output logic              pulse_clr,
    output logic              pulse_inc,
    output logic              finished
);
    localparam int DLY_W = (PANEL_DLY > 0) ? $clog2(PANEL_DLY + 1) : 1;

    pw_state_t         st, nxt;
    logic [CODE_W-1:0] remain;
    logic              dly_zero;

    generate
        if (PANEL_DLY > 0) begin : g_dly
            logic [DLY_W-1:0] dly;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    dly <= '0;
                end else if (st == PW_CLR || st == PW_INC) begin
                    dly <= DLY_W'(PANEL_DLY);
                end else if (st == PW_WAIT && dly != '0) begin
                    dly <= dly - 1'b1;
                end
            end
            assign dly_zero = (dly == '0);
        end else begin : g_nodly
            assign dly_zero = 1'b1;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= PW_IDLE;
        end else begin
            st <= nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (st == PW_IDLE && start) begin
            remain <= code;
        end else if (st == PW_INC) begin
            remain <= remain - 1'b1;
        end
    end

    always_comb begin
        nxt = st;
        unique case (st)
            PW_IDLE: if (start) nxt = PW_CLR;
            PW_CLR:  nxt = PW_WAIT;
            PW_WAIT: if (dly_zero) nxt = (remain == '0) ? PW_FIN : PW_INC;
            PW_INC:  nxt = PW_WAIT;
            PW_FIN:  nxt = PW_IDLE;
            default: nxt = PW_IDLE;
        endcase
    end

    always_comb begin
        pulse_clr = (st == PW_CLR);
        pulse_inc = (st == PW_INC);
        finished  = (st == PW_FIN);
    end
endmodule

// File: rtl/fault_hold_timer.sv
module fault_hold_timer #(
    parameter int HOLD_INNER = 24576,
    parameter int HOLD_OUTER = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expired
);
    localparam int IN_W  = (HOLD_INNER > 1) ? $clog2(HOLD_INNER) : 1;
    localparam int OUT_W = (HOLD_OUTER > 1) ? $clog2(HOLD_OUTER) : 1;

    logic [IN_W-1:0]  inner;
    logic [OUT_W-1:0] outer;
    logic             busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inner <= '0;
            outer <= '0;
            busy  <= 1'b0;
        end else if (start) begin
            inner <= IN_W'(HOLD_INNER - 1);
            outer <= OUT_W'(HOLD_OUTER - 1);
            busy  <= 1'b1;
        end else if (busy) begin
            if (inner != '0) begin
                inner <= inner - 1'b1;
            end else if (outer != '0) begin
                outer <= outer - 1'b1;
                inner <= IN_W'(HOLD_INNER - 1);
            end else begin
                busy <= 1'b0;
            end
        end
    end

    assign expired = busy && (inner == '0) && (outer == '0);
endmodule

// File: rtl/post_selftest_seq.sv
module post_selftest_seq
    import post_selftest_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int SWEEP_LO   = 16,
    parameter int PANEL_DLY  = 5,
    parameter int HOLD_INNER = 24576,
    parameter int HOLD_OUTER = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              rf_we,
    output logic              rf_re,
    output logic [ADDR_W-1:0] rf_addr,
    output logic [DATA_W-1:0] rf_wdata,
    input  logic [DATA_W-1:0] rf_rdata,
    output logic              hold_ld,
    input  logic [DATA_W-1:0] hold_q,
    output logic [DATA_W-1:0] alu_operand,
    input  logic              alu_zero,
    output logic              panel_clr,
    output logic              panel_inc,
    output logic              done,
    output logic              reboot
);
    localparam logic [ADDR_W-1:0] SCRATCH   = ADDR_W'(SWEEP_LO);
    localparam logic [DATA_W-1:0] NZ_OPER   = 16'h00FF;
    localparam logic [IDX_W-1:0]  LAST_PAT  = IDX_W'(NUM_PAT - 1);

    seq_state_t        st, nxt;
    logic [IDX_W-1:0]  pat_idx;
    logic [CODE_W-1:0] fault_code, fault_code_nxt;
    logic [DATA_W-1:0] cur_pat;
    logic [ADDR_W-1:0] sw_addr;
    logic [DATA_W-1:0] sw_data;
    logic              sw_last, sw_load, sw_step;
    logic              pw_start, pw_clr, pw_inc, pw_fin;
    logic              hold_start, hold_expired;
    logic              seq_clr, seq_inc;
    logic              pat_adv;

    assign cur_pat = test_pattern(pat_idx);
    assign sw_data = DATA_W'(sw_addr);

    sweep_addr_ctr #(
        .ADDR_W   (ADDR_W),
        .SWEEP_LO (SWEEP_LO)
    ) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (sw_load),
        .step  (sw_step),
        .addr  (sw_addr),
        .last  (sw_last)
    );

    panel_pulse_writer #(
        .PANEL_DLY (PANEL_DLY)
    ) u_panel (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (pw_start),
        .code      (fault_code),
        .pulse_clr (pw_clr),
        .pulse_inc (pw_inc),
        .finished  (pw_fin)
    );

    fault_hold_timer #(
        .HOLD_INNER (HOLD_INNER),
        .HOLD_OUTER (HOLD_OUTER)
    ) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (hold_start),
        .expired (hold_expired)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_START;
        end else begin
            st <= nxt;
        end
    end

    // step bookkeeping: pattern index and captured fault code
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pat_idx    <= '0;
            fault_code <= '0;
        end else begin
            if (pat_adv) pat_idx <= pat_idx + 1'b1;
            if (nxt == ST_SHOW_GO) fault_code <= fault_code_nxt;
        end
    end

    // next state
    always_comb begin
        nxt            = st;
        fault_code_nxt = fault_code;
        sw_load        = 1'b0;
        sw_step        = 1'b0;
        pat_adv        = 1'b0;
        unique case (st)
            ST_START:      nxt = ST_FLAG_ZERO;
            ST_FLAG_ZERO:  nxt = alu_zero ? ST_FLAG_NZ : ST_HOLD_GO;
            ST_FLAG_NZ:    nxt = alu_zero ? ST_HOLD_GO : ST_MARK_BEGIN;
            ST_MARK_BEGIN: nxt = ST_PAT_WR;
            ST_PAT_WR:     nxt = ST_PAT_RD;
            ST_PAT_RD:     nxt = ST_PAT_CHK_REG;
            ST_PAT_CHK_REG: begin
                if (rf_rdata == cur_pat) begin
                    nxt = ST_PAT_CHK_HOLD;
                end else begin
                    nxt            = ST_SHOW_GO;
                    fault_code_nxt = reg_fault_code(pat_idx);
                end
            end
            ST_PAT_CHK_HOLD: begin
                if (hold_q != cur_pat) begin
                    nxt            = ST_SHOW_GO;
                    fault_code_nxt = hold_fault_code(pat_idx);
                end else if (pat_idx == LAST_PAT) begin
                    nxt     = ST_WALK_WR;
                    sw_load = 1'b1;
                end else begin
                    nxt     = ST_PAT_WR;
                    pat_adv = 1'b1;
                end
            end
            ST_WALK_WR:    nxt = ST_WALK_RD;
            ST_WALK_RD:    nxt = ST_WALK_CHK;
            ST_WALK_CHK: begin
                if (rf_rdata != sw_data) begin
                    nxt            = ST_SHOW_GO;
                    fault_code_nxt = CODE_W'(CODE_WALK);
                end else if (sw_last) begin
                    nxt     = ST_CLR_RD;
                    sw_load = 1'b1;
                end else begin
                    nxt     = ST_WALK_WR;
                    sw_step = 1'b1;
                end
            end
            ST_CLR_RD:     nxt = ST_CLR_CHK;
            ST_CLR_CHK: begin
                if (rf_rdata != sw_data) begin
                    nxt            = ST_SHOW_GO;
                    fault_code_nxt = CODE_W'(CODE_CLEAR);
                end else begin
                    nxt = ST_CLR_WR;
                end
            end
            ST_CLR_WR: begin
                if (sw_last) begin
                    nxt = ST_PASS;
                end else begin
                    nxt     = ST_CLR_RD;
                    sw_step = 1'b1;
                end
            end
            ST_PASS:       nxt = ST_DONE;
            ST_DONE:       nxt = ST_DONE;
            ST_SHOW_GO:    nxt = ST_SHOW_WAIT;
            ST_SHOW_WAIT:  if (pw_fin) nxt = ST_HOLD_GO;
            ST_HOLD_GO:    nxt = ST_HOLD_WAIT;
            ST_HOLD_WAIT:  if (hold_expired) nxt = ST_REBOOT;
            ST_REBOOT:     nxt = ST_HALT;
            ST_HALT:       nxt = ST_HALT;
            default:       nxt = ST_HALT;
        endcase
    end

    // outputs
    always_comb begin
        rf_we       = 1'b0;
        rf_re       = 1'b0;
        rf_addr     = sw_addr;
        rf_wdata    = '0;
        hold_ld     = 1'b0;
        alu_operand = '0;
        seq_clr     = 1'b0;
        seq_inc     = 1'b0;
        pw_start    = 1'b0;
        hold_start  = 1'b0;
        done        = 1'b0;
        reboot      = 1'b0;
        unique case (st)
            ST_START:      seq_clr = 1'b1;
            ST_FLAG_NZ:    alu_operand = NZ_OPER;
            ST_MARK_BEGIN: seq_inc = 1'b1;
            ST_PAT_WR: begin
                rf_we    = 1'b1;
                rf_addr  = SCRATCH;
                rf_wdata = cur_pat;
                hold_ld  = 1'b1;
            end
            ST_PAT_RD: begin
                rf_re   = 1'b1;
                rf_addr = SCRATCH;
            end
            ST_PAT_CHK_REG, ST_PAT_CHK_HOLD: rf_addr = SCRATCH;
            ST_WALK_WR: begin
                rf_we    = 1'b1;
                rf_wdata = sw_data;
            end
            ST_WALK_RD, ST_CLR_RD: rf_re = 1'b1;
            ST_CLR_WR:     rf_we = 1'b1;
            ST_PASS:       seq_inc = 1'b1;
            ST_DONE:       done = 1'b1;
            ST_SHOW_GO:    pw_start = 1'b1;
            ST_HOLD_GO:    hold_start = 1'b1;
            ST_REBOOT:     reboot = 1'b1;
            default:       ;
        endcase
        panel_clr = seq_clr | pw_clr;
        panel_inc = seq_inc | pw_inc;
    end
endmodule

// File: rtl/post_selftest_chk.sv
module post_selftest_chk #(
    parameter int ADDR_W   = 8,
    parameter int SWEEP_LO = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rf_we,
    input logic              rf_re,
    input logic [ADDR_W-1:0] rf_addr,
    input logic              panel_clr,
    input logic              panel_inc,
    input logic              done,
    input logic              reboot
);
    logic rebooted_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rebooted_q <= 1'b0;
        end else if (reboot) begin
            rebooted_q <= 1'b1;
        end
    end

    assert_panel_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(panel_clr && panel_inc));

    assert_rf_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(rf_we && rf_re));

    assert_low_regs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we || rf_re) |-> (rf_addr >= ADDR_W'(SWEEP_LO)));

    assert_done_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    assert_done_no_reboot_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && reboot));

    assert_done_after_mark_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(panel_inc));

    assert_reboot_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reboot |=> !reboot);

    assert_quiet_after_reboot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rebooted_q |-> !(rf_we || rf_re || panel_clr || panel_inc || reboot));
endmodule

bind post_selftest_seq post_selftest_chk #(
    .ADDR_W   (ADDR_W),
    .SWEEP_LO (SWEEP_LO)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rf_we     (rf_we),
    .rf_re     (rf_re),
    .rf_addr   (rf_addr),
    .panel_clr (panel_clr),
    .panel_inc (panel_inc),
    .done      (done),
    .reboot    (reboot)
);

// File: tb/post_selftest_seq_tb.sv
module post_selftest_seq_tb;
    localparam int PDLY  = 4;
    localparam int HIN   = 7;
    localparam int HOUT  = 3;
    localparam int CODE_NONE = -1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rf_we, rf_re, hold_ld, alu_zero;
    logic [7:0]  rf_addr;
    logic [15:0] rf_wdata, rf_rdata, hold_q, alu_operand;
    logic        panel_clr, panel_inc, done, reboot;

    always #5 clk = ~clk;

    post_selftest_seq #(
        .ADDR_W(8), .SWEEP_LO(16), .PANEL_DLY(PDLY),
        .HOLD_INNER(HIN), .HOLD_OUTER(HOUT)
    ) u_dut (
        .clk(clk), .rst_n(rst_n),
        .rf_we(rf_we), .rf_re(rf_re), .rf_addr(rf_addr),
        .rf_wdata(rf_wdata), .rf_rdata(rf_rdata),
        .hold_ld(hold_ld), .hold_q(hold_q),
        .alu_operand(alu_operand), .alu_zero(alu_zero),
        .panel_clr(panel_clr), .panel_inc(panel_inc),
        .done(done), .reboot(reboot)
    );

    // expected data patterns, written independently in octal
    logic [15:0] exp_pat [6] = '{16'o000000, 16'o000125, 16'o000252,
                                 16'o125000, 16'o052400, 16'o177400};

    // fault configuration
    int          zmode = 0;          // 1: flag stuck low, 2: flag stuck high
    int          rd_pat = -1;        // corrupt register read of this pattern
    int          hold_pat = -1;      // corrupt holding load of this pattern
    int          rd_addr_f = -1;     // corrupt nth read of this address
    int          rd_nth = 0;
    int          rd_cnt = 0;

    logic [15:0] ram [256];

    assign alu_zero = (zmode == 1) ? 1'b0 : (zmode == 2) ? 1'b1 : (alu_operand == 16'h0);

    always @(posedge clk) begin
        logic [15:0] flip;
        if (!rst_n) rd_cnt = 0;
        if (rf_we) ram[rf_addr] <= rf_wdata;
        if (rf_re) begin
            flip = 16'h0;
            if (int'(rf_addr) == rd_addr_f) begin
                rd_cnt = rd_cnt + 1;
                if (rd_cnt == rd_nth) flip = 16'h0001;
            end
            if (rd_pat >= 0 && rf_addr == 8'd16 && ram[rf_addr] == exp_pat[rd_pat])
                flip = 16'h0001;
            rf_rdata <= ram[rf_addr] ^ flip;
        end
        if (hold_ld)
            hold_q <= rf_wdata ^ ((hold_pat >= 0 && rf_wdata == exp_pat[hold_pat]) ? 16'h0001 : 16'h0);
    end

    // panel model and pulse monitor
    int  cyc = 0, panel = 0, clr_cnt = 0, reboot_cnt = 0;
    int  min_gap = 1000, last_pulse = 0, reboot_cyc = 0;
    int  n_checks = 0, n_fail = 0;
    bit  finished = 0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (!rst_n) begin
            panel = 0; clr_cnt = 0; reboot_cnt = 0;
            min_gap = 1000; last_pulse = cyc; reboot_cyc = 0;
        end else begin
            if (panel_clr) begin
                panel = 0; clr_cnt = clr_cnt + 1; last_pulse = cyc;
            end else if (panel_inc) begin
                if (clr_cnt >= 2 && (cyc - last_pulse - 1) < min_gap)
                    min_gap = cyc - last_pulse - 1;
                panel = panel + 1; last_pulse = cyc;
            end
            if (reboot) begin
                reboot_cnt = reboot_cnt + 1; reboot_cyc = cyc;
            end
        end
        if (cyc > 150000 && !finished) begin
            finished = 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual cycle %0d expected below 150000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic start_run();
        rst_n = 1'b0;
        for (int a = 0; a < 256; a++) ram[a] = 16'hBEEF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_end();
        int n = 0;
        while (!done && reboot_cnt == 0 && n < 6000) begin
            @(negedge clk);
            n++;
        end
        repeat (30) @(negedge clk);
    endtask

    task automatic clear_faults();
        zmode = 0; rd_pat = -1; hold_pat = -1; rd_addr_f = -1; rd_nth = 0;
    endtask

    // common checks for a run that must end in a fault display
    task automatic check_fault(input string req, input int code);
        check(panel == code, req, panel, code);
        check(reboot_cnt == 1, "R10 single reboot", reboot_cnt, 1);
        check(done == 1'b0, "R12 no done after fault", int'(done), 0);
        check(reboot_cyc - last_pulse >= HIN * HOUT, "R10 hold length",
              reboot_cyc - last_pulse, HIN * HOUT);
        if (code > 0)
            check(min_gap >= PDLY, "R9 increment spacing", min_gap, PDLY);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(done == 1'b0,   "R1 done in reset",   int'(done), 0);
        check(reboot == 1'b0, "R1 reboot in reset", int'(reboot), 0);
        check(rf_we == 1'b0,  "R1 rf_we in reset",  int'(rf_we), 0);
        check(rf_re == 1'b0,  "R1 rf_re in reset",  int'(rf_re), 0);
    endtask

    task automatic t_clean();
        int nonzero = 0, touched = 0;
        clear_faults();
        start_run();
        wait_end();
        check(done == 1'b1, "R3 done after pass", int'(done), 1);
        check(panel == 2, "R3 panel reads 2", panel, 2);
        check(reboot_cnt == 0, "R12 no reboot on pass", reboot_cnt, 0);
        for (int a = 16; a < 256; a++) if (ram[a] != 16'h0) nonzero++;
        check(nonzero == 0, "R7 sweep range cleared", nonzero, 0);
        for (int a = 0; a < 16; a++) if (ram[a] != 16'hBEEF) touched++;
        check(touched == 0, "R8 low registers untouched", touched, 0);
    endtask

    task automatic t_flag(input int mode);
        clear_faults();
        zmode = mode;
        start_run();
        wait_end();
        check_fault("R2 flag fault leaves panel 0", 0);
    endtask

    task automatic t_pat_reg(input int i);
        clear_faults();
        rd_pat = i;
        start_run();
        wait_end();
        check_fault($sformatf("R4 register pattern %0d code", i), 4 + 2 * i);
    endtask

    task automatic t_pat_hold(input int i);
        clear_faults();
        hold_pat = i;
        start_run();
        wait_end();
        check_fault($sformatf("R5 holding pattern %0d code", i), 5 + 2 * i);
    endtask

    task automatic t_sweep(input int addr, input int nth, input int code, input string req);
        clear_faults();
        rd_addr_f = addr;
        rd_nth = nth;
        start_run();
        wait_end();
        check_fault(req, code);
    endtask

    initial begin
        t_reset();
        t_clean();
        t_flag(1);
        t_flag(2);
        for (int i = 0; i < 6; i++) t_pat_reg(i);
        for (int i = 0; i < 6; i++) t_pat_hold(i);
        t_sweep(255, 1, 16, "R6 walk fault top address");
        t_sweep(100, 1, 16, "R6 walk fault mid address");
        t_sweep(16, 7, 16, "R6 walk fault bottom address");
        t_sweep(255, 2, 17, "R7 clear fault top address");
        t_sweep(16, 8, 17, "R7 clear fault bottom address");
        t_clean();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule